// File: doc/BRIEF.md
# Pseudo-Random Noise Channel

This block produces the one-bit noise waveform of a sound generator. A 15-bit shift register with feedback is advanced once per rate event and its lowest bit is the output. A type bit chooses between white noise, where the feedback mixes two register bits and the pattern is long and irregular, and periodic noise, where the output bit is fed straight back and a 15-step pattern repeats.

The rate event comes from one of two places. In the first, a divider counts prescaled ticks. In the second, the block follows the toggle strobe of tone channel 2. Whichever source is selected, the register advances on the rising half of the divided square wave.

A write to the noise control register restarts the channel. The register is reloaded with its seed and the divider starts over from zero. The control value is presented on a 3-bit input. The write strobe only marks when a new value has been written.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, the shift register holds the seed (a single 1 in bit 14, zeros elsewhere), so `noise_out` is 0.
- R2: With rate field `ctrl_val[1:0]` = 00, the register advances on the 16th tick after a restart and then on every 32nd tick (a half period of HALF_BASE = 16 ticks). Each advance moves the register one place toward bit 0 and inserts the feedback bit at bit 14.
- R3: Rate field 01 doubles the half period to 32 ticks and rate field 10 quadruples it to 64 ticks. Only cycles with `tick_in` high count.
- R4: With rate field 11, the register advances on the 1st, 3rd, 5th, ... `tone2_toggle` pulse after a restart, and `tick_in` has no effect.
- R5: With `ctrl_val[2]` = 1 (white), the feedback is bit 0 XOR bit 1. Over one full period of 32767 advances, `noise_out` is 1 after exactly 16384 of them.
- R6: With `ctrl_val[2]` = 0 (periodic), the feedback is bit 0 alone. After a restart, `noise_out` first becomes 1 after the 14th advance and stays 1 for a single advance.
- R7: A cycle with `ctrl_wr` high reloads the seed and clears the divider count and phase, whatever the previous state.
- R8: When `ctrl_wr` falls in the same cycle as a rate event, the restart wins and no advance takes place.
- R9: With a fixed rate field (00, 01 or 10), cycles with `tick_in` low do not move the divider, and `tone2_toggle` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Prescaled tick, one cycle wide |
| tone2_toggle | input | 1 | One-cycle strobe each time tone channel 2 flips its output |
| ctrl_val | input | 3 | Noise control value: bit 2 = 1 white, 0 periodic; bits 1:0 rate field |
| ctrl_wr | input | 1 | High for one cycle when the noise control register is written |
| noise_out | output | 1 | Noise waveform (bit 0 of the shift register) |

## Verification
A restart and a rate event can land in the same cycle. The event can be a divider expiry or a tone channel 2 toggle. The bench provokes both cases. For the divider, it counts ticks so that the write strobe rises on exactly the tick that would complete a half period. For the tone source, it raises the write strobe together with a toggle pulse. In each case the output and the later advance times are compared with a cycle-by-cycle model built from the requirements. The check passes only if no advance happened and the next advance comes a full half period after the write.

// File: rtl/noise_pkg.sv
package noise_pkg;

  typedef enum logic [1:0] {
    RATE_DIV1 = 2'b00,
    RATE_DIV2 = 2'b01,
    RATE_DIV4 = 2'b10,
    RATE_TONE = 2'b11
  } noise_rate_e;

  typedef struct packed {
    logic        white;
    noise_rate_e rate;
  } noise_ctrl_t;

endpackage

// File: rtl/noise_rate_div.sv
module noise_rate_div
  import noise_pkg::*;
#(
  parameter int HALF_BASE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        tick,
  input  logic        tone_tog,
  input  noise_rate_e rate,
  output logic        shift_en
);

  localparam int CW = $clog2(HALF_BASE * 4);

  logic [CW-1:0] lim_m1 [4];
  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          fixed_src;
  logic          expire;
  logic          step;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int SH = (g > 2) ? 2 : g;
    assign lim_m1[g] = CW'((HALF_BASE << SH) - 1);
  end

  always_comb begin
    fixed_src = (rate != RATE_TONE);
    expire    = tick && (cnt_q >= lim_m1[rate]);
    step      = fixed_src ? expire : tone_tog;
    shift_en  = step && !ph_q && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (fixed_src) begin
      if (tick) begin
        if (expire) begin
          cnt_q <= '0;
          ph_q  <= !ph_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (tone_tog) begin
      ph_q <= !ph_q;
    end
  end

endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         shift_en,
  input  logic         white,
  output logic [W-1:0] state_q
);

  localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

  logic fb;

  always_comb begin
    if (white) fb = state_q[0] ^ state_q[1];
    else       fb = state_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state_q <= SEED;
    end else if (shift_en) begin
      state_q <= {fb, state_q[W-1:1]};
    end
  end

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_pkg::*;
#(
  parameter int LFSR_W    = 15,
  parameter int HALF_BASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic       tone2_toggle,
  input  logic [2:0] ctrl_val,
  input  logic       ctrl_wr,
  output logic       noise_out
);

  noise_ctrl_t       ctrl;
  logic              shift_en;
  logic [LFSR_W-1:0] lfsr_q;

  assign ctrl = noise_ctrl_t'(ctrl_val);

  noise_rate_div #(.HALF_BASE(HALF_BASE)) u_div (
    .clk      (clk),
    .rst      (rst),
    .restart  (ctrl_wr),
    .tick     (tick_in),
    .tone_tog (tone2_toggle),
    .rate     (ctrl.rate),
    .shift_en (shift_en)
  );

  noise_shift_reg #(.W(LFSR_W)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .restart  (ctrl_wr),
    .shift_en (shift_en),
    .white    (ctrl.white),
    .state_q  (lfsr_q)
  );

  assign noise_out = lfsr_q[0];

endmodule

// File: rtl/noise_lfsr_gen_chk.sv
module noise_lfsr_gen_chk #(
  parameter int W = 15
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_in,
  input logic         tone2_toggle,
  input logic [2:0]   ctrl_val,
  input logic         ctrl_wr,
  input logic [W-1:0] lfsr_q,
  input logic         noise_out
);

  localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

  logic per_clean_q;

  always_ff @(posedge clk) begin
    if (rst)          per_clean_q <= 1'b0;
    else if (ctrl_wr) per_clean_q <= !ctrl_val[2];
    else              per_clean_q <= per_clean_q && !ctrl_val[2];
  end

  // R7, R8: a write always lands on the seed, whatever else happens in that cycle
  p_restart_seed_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (lfsr_q == SEED) && !noise_out);

  // R2: the register either holds or moves one place toward bit 0
  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> ($stable(lfsr_q) || (lfsr_q[W-2:0] == $past(lfsr_q[W-1:1]))));

  // R9: in fixed-rate modes a cycle without a tick cannot advance
  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && (ctrl_val[1:0] != 2'b11) && !tick_in) |=> $stable(lfsr_q));

  // R4: in tone-follow mode only a toggle pulse can advance
  p_tone_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && (ctrl_val[1:0] == 2'b11) && !tone2_toggle) |=> $stable(lfsr_q));

  // R6: periodic mode since a restart keeps the single 1 circulating
  p_periodic_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    per_clean_q |-> ($countones(lfsr_q) == 1));

endmodule

bind noise_lfsr_gen noise_lfsr_gen_chk #(.W(LFSR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_in      (tick_in),
  .tone2_toggle (tone2_toggle),
  .ctrl_val     (ctrl_val),
  .ctrl_wr      (ctrl_wr),
  .lfsr_q       (lfsr_q),
  .noise_out    (noise_out)
);

// File: tb/noise_lfsr_gen_bench.sv
`timescale 1ns/1ps
module noise_lfsr_gen_bench;

  localparam int H    = 16;
  localparam int W    = 15;
  localparam logic [W-1:0] SEED = 15'h4000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic       tone2_toggle = 1'b0;
  logic [2:0] ctrl_val = 3'b000;
  logic       ctrl_wr = 1'b0;
  logic       noise_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] m_lfsr;
  int           m_cnt;
  bit           m_ph;
  bit           m_shifted;

  always #2.5 clk = !clk;

  noise_lfsr_gen u_noise_lfsr_gen (
    .clk          (clk),
    .rst          (rst),
    .tick_in      (tick_in),
    .tone2_toggle (tone2_toggle),
    .ctrl_val     (ctrl_val),
    .ctrl_wr      (ctrl_wr),
    .noise_out    (noise_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: noise_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] adv(input logic [W-1:0] s, input bit white);
    logic fb;
    fb = white ? (s[0] ^ s[1]) : s[0];
    return {fb, s[W-1:1]};
  endfunction

  // one clock: drive at negedge, model at posedge, compare just after it
  task automatic cyc(input bit tk, input bit tg, input bit wr, input logic [2:0] v,
                     input string req);
    int lim;
    tick_in = tk; tone2_toggle = tg; ctrl_wr = wr; ctrl_val = v;
    @(posedge clk);
    #1;
    m_shifted = 0;
    if (wr) begin
      m_lfsr = SEED; m_cnt = 0; m_ph = 0;
    end else if (v[1:0] == 2'b11) begin
      if (tg) begin
        m_ph = !m_ph;
        if (m_ph) begin m_lfsr = adv(m_lfsr, v[2]); m_shifted = 1; end
      end
    end else if (tk) begin
      lim = H << v[1:0];
      m_cnt++;
      if (m_cnt >= lim) begin
        m_cnt = 0;
        m_ph  = !m_ph;
        if (m_ph) begin m_lfsr = adv(m_lfsr, v[2]); m_shifted = 1; end
      end
    end
    check(req, noise_out, m_lfsr[0]);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int first_one;
    int ones;
    int shifts;
    m_lfsr = SEED; m_cnt = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", noise_out, 1'b0);
    rst = 1'b0;
    cyc(0, 0, 0, 3'b100, "R1 after reset");
    check("R1 seed output", noise_out, 1'b0);

    // R2 and R5: white noise, rate 00, a tick every cycle
    cyc(0, 0, 1, 3'b100, "R7 write");
    for (int i = 0; i < 40 * 32; i++) cyc(1, 0, 0, 3'b100, "R2 rate00 white");

    // R3 and R9: rate 01 with a tick every other cycle, toggles ignored
    cyc(0, 0, 1, 3'b101, "R7 write");
    for (int i = 0; i < 20 * 128; i++) cyc(i[0], 1, 0, 3'b101, "R3 R9 rate01 sparse ticks");

    // R3: rate 10, a tick every cycle
    cyc(0, 0, 1, 3'b110, "R7 write");
    for (int i = 0; i < 20 * 128; i++) cyc(1, 0, 0, 3'b110, "R3 rate10");

    // R6: periodic, rate 00; the first 1 appears on tick 16 + 13*32 = 432
    cyc(0, 0, 1, 3'b000, "R7 write");
    first_one = -1;
    ones = 0;
    for (int i = 1; i <= 30 * 32; i++) begin
      cyc(1, 0, 0, 3'b000, "R6 periodic");
      if (noise_out === 1'b1 && first_one < 0) first_one = i;
      if (noise_out === 1'b1) ones++;
    end
    check_int("R6 first 1 at tick", first_one, 432);
    check_int("R6 high for one advance per cycle of 15", ones, 2 * 32);

    // R8: write on the very tick that would complete a half period
    cyc(0, 0, 1, 3'b100, "R7 write");
    for (int i = 0; i < H - 1; i++) cyc(1, 0, 0, 3'b100, "R8 lead-in");
    cyc(1, 0, 1, 3'b100, "R8 write beats divider expiry");
    check("R8 seed kept", noise_out, 1'b0);
    for (int i = 0; i < 3 * 32; i++) cyc(1, 0, 0, 3'b100, "R8 restart timing");

    // R4: tone-follow mode, ticks ignored, irregular toggles
    cyc(0, 0, 1, 3'b111, "R7 write");
    for (int i = 0; i < 600; i++) cyc(1, (i % 3) == 0, 0, 3'b111, "R4 tone follow");
    cyc(0, 1, 1, 3'b111, "R8 write beats tone toggle");
    cyc(0, 1, 0, 3'b111, "R8 first toggle after write advances");

    // R7: restart in the middle of a white run
    for (int i = 0; i < 50; i++) cyc(0, 1, 0, 3'b111, "R4 run");
    cyc(0, 0, 1, 3'b111, "R7 restart mid run");
    check("R7 seed output", noise_out, 1'b0);

    // R5: one full period at a toggle every cycle, count ones per advance
    ones = 0;
    shifts = 0;
    while (shifts < 32767) begin
      cyc(0, 1, 0, 3'b111, "R5 full period");
      if (m_shifted) begin
        shifts++;
        if (noise_out === 1'b1) ones++;
      end
    end
    check_int("R5 ones over full period", ones, 16384);

    // R9: fixed rate, no ticks, toggles only: nothing moves
    cyc(0, 0, 1, 3'b100, "R7 write");
    for (int i = 0; i < 200; i++) cyc(0, 1, 0, 3'b100, "R9 no ticks");
    for (int i = 0; i < H; i++) cyc(1, 0, 0, 3'b100, "R9 count resumes");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule